// File: doc/BRIEF.md
# Power-up phase sequencer

This block walks a multi-channel regulator controller from an enabled pin to normal running in three ordered phases. In the first phase it waits until the enable pin, the main input supply, the reference and both internal supply monitors are all good, then holds an active-low internal reset for a fixed number of clocks. In the second phase it reads a small configuration memory, one word at a time over a request/valid port, into working registers that set the pin directions, the serial-bus pin role and the channel enable sources. In the third phase it raises a ready flag, allows the serial-bus engine to acknowledge the host, and drives the per-channel enables.

The state machine has four states: `PH_IDLE` (no good supply, reset held), `PH_RESET` (reset window counting), `PH_LOAD` (configuration transfer) and `PH_READY` (normal operation). The transitions are: `PH_IDLE -> PH_RESET` when supply is good; `PH_RESET -> PH_LOAD` when the window count expires; `PH_LOAD -> PH_READY` when the last word is accepted; `PH_READY -> PH_RESET` on a soft-reset request; and any of `PH_RESET`, `PH_LOAD`, `PH_READY` `-> PH_IDLE` when supply is lost. Supply loss takes priority over every other transition.

Top module: `pwrseq_top`

## Requirements
- R1: `supply_ok` is the AND of `en_pin`, `vin_ok`, `ref_stable`, `vcc_ok` and `vdd_ok`. While it is low the block stays idle, with `cfg_xfer` and `chip_ready` low.
- R2: Once `supply_ok` is high, `sys_rst_n` stays low for exactly 8 clock cycles in the reset state. It then rises in the same cycle as `cfg_xfer`.
- R3: While loading, `cfg_rd_req` is high and `cfg_rd_addr` steps through 0, 1, 2 in order. Each address is held until a cycle with `cfg_rd_valid` high. `chip_ready` rises in the cycle after the last word is accepted, so the load lasts 3*(wait+1) cycles.
- R4: Word 0 sets the pin roles. Bits [7:0] give the pin directions (1 = output) and appear on `gpio_oe`. Bit 8 selects serial-bus mode, which shows on `bus_role` and forces `gpio_oe[4]` and `gpio_oe[5]` to 0 because those pins carry bus data and clock.
- R5: `chip_ready` and `bus_ack_en` are high only in the ready state, which is reached only directly from the load state.
- R6: `ch_en[c]` is the OR of always-on bit c of word 1 (bits [3:0]), the qualified pin of channel c, and host enable bit c. All bits are 0 outside the ready state.
- R7: Word 2 holds one 4-bit field per channel at bits [4c+3:4c]: bit 3 selects pin enable and bits 2:0 give the pin index. The pin qualifies only if it is high, its direction bit is 0, and it is not pin 4 or 5 while serial-bus mode is set.
- R8: `host_en_we` loads `host_en_data` into the host enable register only in the ready state. The register clears whenever the block leaves the ready state.
- R9: A `soft_rst_req` seen in the ready state returns the block to the reset state. In the next cycle `sys_rst_n` and `chip_ready` are low, and a full 8-cycle window follows. In any other state the request is ignored.
- R10: If `supply_ok` drops in any state, the block is idle one clock later, with `chip_ready`, `cfg_xfer` and all `ch_en` low.
- R11: The configuration registers are zero whenever `sys_rst_n` is low, so `gpio_oe` is 0 and `bus_role` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| en_pin | input | 1 | Device enable pin |
| vin_ok | input | 1 | Main input supply present |
| ref_stable | input | 1 | Reference reports stable |
| vcc_ok | input | 1 | First internal supply in range |
| vdd_ok | input | 1 | Second internal supply in range |
| soft_rst_req | input | 1 | Soft-reset command from the serial-bus engine |
| gpio_in | input | 8 | General-purpose pin levels |
| host_en_we | input | 1 | Host write strobe for the channel enable register |
| host_en_data | input | 4 | Host channel enable bits |
| cfg_rd_req | output | 1 | Configuration memory read request |
| cfg_rd_addr | output | 4 | Configuration word address |
| cfg_rd_valid | input | 1 | Read data valid for the current address |
| cfg_rd_data | input | 16 | Configuration word |
| supply_ok | output | 1 | All supply conditions met |
| sys_rst_n | output | 1 | Internal active-low reset |
| cfg_xfer | output | 1 | Configuration transfer in progress |
| chip_ready | output | 1 | Normal operation flag |
| bus_ack_en | output | 1 | Serial-bus engine may acknowledge the host |
| bus_role | output | 1 | Pins 4 and 5 serve as bus data and clock |
| gpio_oe | output | 8 | Pin output enables |
| ch_en | output | 4 | Channel enables |

## Verification
A state register stuck or skipped shows at once on the phase flags: `sys_rst_n`, `cfg_xfer` and `chip_ready` decode straight from the state. A wrong window or load counter moves the rising edge of `cfg_xfer` or `chip_ready` by whole cycles, so the bench measures each phase length exactly. A wrong captured configuration word appears on `gpio_oe` or `bus_role` from the first ready cycle, and a wrong enable term appears in `ch_en` only for the pin patterns that exercise it. For that reason the bench sweeps every pin pattern and every host mask under several configurations.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RESET = 2'd1,
        PH_LOAD  = 2'd2,
        PH_READY = 2'd3
    } phase_e;

    // Configuration words read during the load phase, in this order.
    localparam int CFG_WORDS = 3;
    localparam int WORD_PINS = 0;  // directions and bus-mode select
    localparam int WORD_AON  = 1;  // always-on channel mask
    localparam int WORD_MAP  = 2;  // per-channel pin-enable fields

endpackage

// File: rtl/pwrseq_supply_mon.sv
module pwrseq_supply_mon (
    input  logic en_pin,
    input  logic vin_ok,
    input  logic ref_stable,
    input  logic vcc_ok,
    input  logic vdd_ok,
    output logic supply_ok
);

    // Internal supplies follow the main input; all conditions must hold.
    assign supply_ok = en_pin & vin_ok & ref_stable & vcc_ok & vdd_ok;

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int RST_CYCLES = 8,
    parameter int IDX_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             soft_rst_req,
    input  logic             rd_valid,
    output phase_e           phase,
    output logic             rd_req,
    output logic [IDX_W-1:0] load_idx,
    output logic             load_we,
    output logic             clr_cfg,
    output logic             clr_host,
    output logic             sys_rst_n,
    output logic             cfg_xfer,
    output logic             chip_ready
);

    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CFG_WORDS - 1);

    phase_e           state_q;
    phase_e           state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;

    // Next-state selection; supply loss wins over every other condition.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (supply_ok) state_d = PH_RESET;
            end
            PH_RESET: begin
                if (!supply_ok)            state_d = PH_IDLE;
                else if (cnt_q == CNT_LAST) state_d = PH_LOAD;
            end
            PH_LOAD: begin
                if (!supply_ok)                       state_d = PH_IDLE;
                else if (rd_valid && idx_q == IDX_LAST) state_d = PH_READY;
            end
            PH_READY: begin
                if (!supply_ok)        state_d = PH_IDLE;
                else if (soft_rst_req) state_d = PH_RESET;
            end
        endcase
    end

    // State register with window counter and load index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PH_RESET && state_d == PH_RESET)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
            if (state_q != PH_LOAD)
                idx_q <= '0;
            else if (rd_valid)
                idx_q <= idx_q + 1'b1;
        end
    end

    // Moore outputs decoded from the current state.
    always_comb begin
        sys_rst_n  = 1'b0;
        cfg_xfer   = 1'b0;
        chip_ready = 1'b0;
        rd_req     = 1'b0;
        unique case (state_q)
            PH_IDLE:  ;
            PH_RESET: ;
            PH_LOAD: begin
                sys_rst_n = 1'b1;
                cfg_xfer  = 1'b1;
                rd_req    = 1'b1;
            end
            PH_READY: begin
                sys_rst_n  = 1'b1;
                chip_ready = 1'b1;
            end
        endcase
    end

    assign phase    = state_q;
    assign load_idx = idx_q;
    assign load_we  = rd_req & rd_valid;
    assign clr_cfg  = (state_d == PH_IDLE) || (state_d == PH_RESET);
    assign clr_host = (state_d != PH_READY);

endmodule

// File: rtl/pwrseq_cfg_regs.sv
module pwrseq_cfg_regs
    import pwrseq_pkg::*;
#(
    parameter int N_GPIO = 8,
    parameter int N_CH   = 4,
    parameter int FLD_W  = 4,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [DATA_W-1:0]      data,
    output logic [N_GPIO-1:0]      dir,
    output logic                   bus_mode,
    output logic [N_CH-1:0]        aon,
    output logic [N_CH*FLD_W-1:0]  pin_map
);

    logic [N_GPIO:0]         pins_q;
    logic [N_CH-1:0]         aon_q;
    logic [N_CH*FLD_W-1:0]   map_q;
    logic                    unused_data;

    assign unused_data = ^data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '0;
            aon_q  <= '0;
            map_q  <= '0;
        end else if (clr) begin
            pins_q <= '0;
            aon_q  <= '0;
            map_q  <= '0;
        end else if (we) begin
            if (idx == IDX_W'(WORD_PINS)) pins_q <= data[N_GPIO:0];
            if (idx == IDX_W'(WORD_AON))  aon_q  <= data[N_CH-1:0];
            if (idx == IDX_W'(WORD_MAP))  map_q  <= data[N_CH*FLD_W-1:0];
        end
    end

    assign dir      = pins_q[N_GPIO-1:0];
    assign bus_mode = pins_q[N_GPIO];
    assign aon      = aon_q;
    assign pin_map  = map_q;

endmodule

// File: rtl/pwrseq_chan_en.sv
module pwrseq_chan_en #(
    parameter int N_GPIO  = 8,
    parameter int N_CH    = 4,
    parameter int SEL_W   = 3,
    parameter int FLD_W   = 4,
    parameter int SDA_IDX = 4,
    parameter int SCL_IDX = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ready,
    input  logic                  clr_host,
    input  logic                  host_we,
    input  logic [N_CH-1:0]       host_data,
    input  logic [N_GPIO-1:0]     gpio_in,
    input  logic [N_GPIO-1:0]     dir,
    input  logic                  bus_mode,
    input  logic [N_CH-1:0]       aon,
    input  logic [N_CH*FLD_W-1:0] pin_map,
    output logic [N_CH-1:0]       ch_en
);

    logic [N_CH-1:0] host_q;

    // Host enables: written only while ready, cleared on leaving ready.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            host_q <= '0;
        else if (clr_host)
            host_q <= '0;
        else if (host_we && ready)
            host_q <= host_data;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [FLD_W-1:0] fld;
        logic [SEL_W-1:0] pin;
        logic             use_pin;
        logic             bus_pin;
        logic             qual;

        assign fld     = pin_map[c*FLD_W +: FLD_W];
        assign pin     = fld[SEL_W-1:0];
        assign use_pin = fld[SEL_W];
        assign bus_pin = bus_mode &&
                         (pin == SEL_W'(SDA_IDX) || pin == SEL_W'(SCL_IDX));
        assign qual    = use_pin && gpio_in[pin] && !dir[pin] && !bus_pin;
        assign ch_en[c] = ready && (aon[c] || qual || host_q[c]);
    end

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int N_GPIO     = 8,
    parameter int RST_CYCLES = 8,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 16,
    parameter int SDA_IDX    = 4,
    parameter int SCL_IDX    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_pin,
    input  logic              vin_ok,
    input  logic              ref_stable,
    input  logic              vcc_ok,
    input  logic              vdd_ok,
    input  logic              soft_rst_req,
    input  logic [N_GPIO-1:0] gpio_in,
    input  logic              host_en_we,
    input  logic [N_CH-1:0]   host_en_data,
    output logic              cfg_rd_req,
    output logic [ADDR_W-1:0] cfg_rd_addr,
    input  logic              cfg_rd_valid,
    input  logic [DATA_W-1:0] cfg_rd_data,
    output logic              supply_ok,
    output logic              sys_rst_n,
    output logic              cfg_xfer,
    output logic              chip_ready,
    output logic              bus_ack_en,
    output logic              bus_role,
    output logic [N_GPIO-1:0] gpio_oe,
    output logic [N_CH-1:0]   ch_en
);

    localparam int SEL_W = (N_GPIO > 1) ? $clog2(N_GPIO) : 1;
    localparam int FLD_W = SEL_W + 1;
    localparam int IDX_W = $clog2(CFG_WORDS + 1);

    phase_e                 phase;
    logic [IDX_W-1:0]       load_idx;
    logic                   load_we;
    logic                   clr_cfg;
    logic                   clr_host;
    logic [N_GPIO-1:0]      dir;
    logic                   bus_mode;
    logic [N_CH-1:0]        aon;
    logic [N_CH*FLD_W-1:0]  pin_map;
    logic [N_GPIO-1:0]      bus_mask;
    logic                   unused_phase;

    pwrseq_supply_mon u_mon (
        .en_pin     (en_pin),
        .vin_ok     (vin_ok),
        .ref_stable (ref_stable),
        .vcc_ok     (vcc_ok),
        .vdd_ok     (vdd_ok),
        .supply_ok  (supply_ok)
    );

    pwrseq_fsm #(
        .RST_CYCLES (RST_CYCLES),
        .IDX_W      (IDX_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .soft_rst_req (soft_rst_req),
        .rd_valid     (cfg_rd_valid),
        .phase        (phase),
        .rd_req       (cfg_rd_req),
        .load_idx     (load_idx),
        .load_we      (load_we),
        .clr_cfg      (clr_cfg),
        .clr_host     (clr_host),
        .sys_rst_n    (sys_rst_n),
        .cfg_xfer     (cfg_xfer),
        .chip_ready   (chip_ready)
    );

    pwrseq_cfg_regs #(
        .N_GPIO (N_GPIO),
        .N_CH   (N_CH),
        .FLD_W  (FLD_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_cfg),
        .we       (load_we),
        .idx      (load_idx),
        .data     (cfg_rd_data),
        .dir      (dir),
        .bus_mode (bus_mode),
        .aon      (aon),
        .pin_map  (pin_map)
    );

    pwrseq_chan_en #(
        .N_GPIO  (N_GPIO),
        .N_CH    (N_CH),
        .SEL_W   (SEL_W),
        .FLD_W   (FLD_W),
        .SDA_IDX (SDA_IDX),
        .SCL_IDX (SCL_IDX)
    ) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (chip_ready),
        .clr_host  (clr_host),
        .host_we   (host_en_we),
        .host_data (host_en_data),
        .gpio_in   (gpio_in),
        .dir       (dir),
        .bus_mode  (bus_mode),
        .aon       (aon),
        .pin_map   (pin_map),
        .ch_en     (ch_en)
    );

    // Bus pins are released from output duty when serial-bus mode is set.
    for (genvar p = 0; p < N_GPIO; p++) begin : g_mask
        assign bus_mask[p] = bus_mode && (p == SDA_IDX || p == SCL_IDX);
    end

    assign unused_phase = ^phase;
    assign cfg_rd_addr  = ADDR_W'(load_idx);
    assign gpio_oe      = dir & ~bus_mask;
    assign bus_role     = bus_mode;
    assign bus_ack_en   = chip_ready;

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
    parameter int N_CH   = 4,
    parameter int N_GPIO = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              soft_rst_req,
    input logic              cfg_rd_req,
    input logic              cfg_rd_valid,
    input logic [ADDR_W-1:0] cfg_rd_addr,
    input logic              sys_rst_n,
    input logic              cfg_xfer,
    input logic              chip_ready,
    input logic              bus_role,
    input logic [N_GPIO-1:0] gpio_oe,
    input logic [N_CH-1:0]   ch_en
);

    a_r1_idle_without_supply: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !cfg_xfer && !chip_ready);

    a_r2_release_into_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> cfg_xfer);

    a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_req && !cfg_rd_valid && supply_ok |=> cfg_rd_req && $stable(cfg_rd_addr));

    a_r5_ready_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_ready) |-> $past(cfg_xfer));

    a_r6_enables_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_ready |-> ch_en == '0);

    a_r9_soft_restart: assert property (@(posedge clk) disable iff (!rst_n)
        chip_ready && soft_rst_req && supply_ok |=> !sys_rst_n && !chip_ready);

    a_r10_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> ch_en == '0 && !chip_ready);

    a_r11_cleared_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> gpio_oe == '0 && !bus_role);

endmodule

bind pwrseq_top pwrseq_chk #(
    .N_CH   (N_CH),
    .N_GPIO (N_GPIO),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .soft_rst_req (soft_rst_req),
    .cfg_rd_req   (cfg_rd_req),
    .cfg_rd_valid (cfg_rd_valid),
    .cfg_rd_addr  (cfg_rd_addr),
    .sys_rst_n    (sys_rst_n),
    .cfg_xfer     (cfg_xfer),
    .chip_ready   (chip_ready),
    .bus_role     (bus_role),
    .gpio_oe      (gpio_oe),
    .ch_en        (ch_en)
);

// File: tb/sim_pwrseq_top.sv
`timescale 1ns/1ps
module sim_pwrseq_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_pin, vin_ok, ref_stable, vcc_ok, vdd_ok;
    logic        soft_rst_req;
    logic [7:0]  gpio_in;
    logic        host_en_we;
    logic [3:0]  host_en_data;
    logic        cfg_rd_req;
    logic [3:0]  cfg_rd_addr;
    logic        cfg_rd_valid;
    logic [15:0] cfg_rd_data;
    logic        supply_ok, sys_rst_n, cfg_xfer, chip_ready, bus_ack_en, bus_role;
    logic [7:0]  gpio_oe;
    logic [3:0]  ch_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwrseq_top u0 (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .vin_ok(vin_ok),
        .ref_stable(ref_stable), .vcc_ok(vcc_ok), .vdd_ok(vdd_ok),
        .soft_rst_req(soft_rst_req), .gpio_in(gpio_in),
        .host_en_we(host_en_we), .host_en_data(host_en_data),
        .cfg_rd_req(cfg_rd_req), .cfg_rd_addr(cfg_rd_addr),
        .cfg_rd_valid(cfg_rd_valid), .cfg_rd_data(cfg_rd_data),
        .supply_ok(supply_ok), .sys_rst_n(sys_rst_n), .cfg_xfer(cfg_xfer),
        .chip_ready(chip_ready), .bus_ack_en(bus_ack_en), .bus_role(bus_role),
        .gpio_oe(gpio_oe), .ch_en(ch_en)
    );

    // Configuration memory model with a programmable wait per word.
    logic [15:0] mem [0:2];
    int          lat = 0;
    int          wcnt = 0;
    logic        log_clr = 1'b0;
    logic [3:0]  alog [0:7];
    int          acnt = 0;

    assign cfg_rd_valid = cfg_rd_req && (wcnt == lat);
    assign cfg_rd_data  = (cfg_rd_addr < 4'd3) ? mem[cfg_rd_addr[1:0]] : 16'h0;

    always @(posedge clk) begin
        if (!cfg_rd_req || cfg_rd_valid) wcnt <= 0;
        else                             wcnt <= wcnt + 1;
        if (log_clr) acnt <= 0;
        else if (cfg_rd_req && cfg_rd_valid && acnt < 8) begin
            alog[acnt] <= cfg_rd_addr;
            acnt <= acnt + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_ch(input logic [7:0] g, input logic [3:0] h);
        logic [7:0] dir;
        logic       bus;
        logic [3:0] f;
        logic [2:0] p;
        logic       q;
        logic [3:0] r;
        dir = mem[0][7:0];
        bus = mem[0][8];
        for (int c = 0; c < 4; c++) begin
            f = mem[2][4*c +: 4];
            p = f[2:0];
            q = f[3] && g[p] && !dir[p] && !(bus && (p == 3'd4 || p == 3'd5));
            r[c] = mem[1][c] || q || h[c];
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_oe();
        return mem[0][7:0] & ~(mem[0][8] ? 8'h30 : 8'h00);
    endfunction

    task automatic idle_checks(input string req);
        chk(req, "sys_rst_n", sys_rst_n, 1'b0);
        chk(req, "cfg_xfer", cfg_xfer, 1'b0);
        chk(req, "chip_ready", chip_ready, 1'b0);
        chk(req, "bus_ack_en", bus_ack_en, 1'b0);
        chk(req, "ch_en", ch_en, 4'h0);
        chk("R11", "gpio_oe", gpio_oe, 8'h00);
        chk("R11", "bus_role", bus_role, 1'b0);
    endtask

    // Count reset cycles from a given point until cfg_xfer appears.
    task automatic count_reset(input int expn, input string req);
        int n = 0;
        int early = 0;
        do begin
            @(negedge clk);
            n++;
            if (!cfg_xfer && sys_rst_n) early++;
        end while (!cfg_xfer && n < 100);
        chk(req, "reset window length", n, expn);
        chk(req, "sys_rst_n high early", early, 0);
        chk(req, "sys_rst_n with cfg_xfer", sys_rst_n, 1'b1);
    endtask

    task automatic count_load(input string req);
        int m = 1;
        @(negedge clk);
        while (!chip_ready && m < 200) begin
            m++;
            @(negedge clk);
        end
        chk(req, "load length", m, 3 * (lat + 1));
        chk("R5", "ready", chip_ready, 1'b1);
        chk("R5", "bus_ack_en", bus_ack_en, 1'b1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en_pin = 0; vin_ok = 0; ref_stable = 0; vcc_ok = 0; vdd_ok = 0;
        soft_rst_req = 0; gpio_in = 8'h00; host_en_we = 0; host_en_data = 4'h0;
        mem[0] = 16'h0; mem[1] = 16'h0; mem[2] = 16'h0;
        repeat (3) @(negedge clk);
        idle_checks("R2");
        chk("R3", "rd_req in reset", cfg_rd_req, 1'b0);
        rst_n = 1'b1;

        // R1: every incomplete supply combination keeps the block idle.
        for (int k = 0; k < 31; k++) begin
            {en_pin, vin_ok, ref_stable, vcc_ok, vdd_ok} = 5'(k);
            repeat (2) @(negedge clk);
            chk("R1", "supply_ok", supply_ok, 1'b0);
            chk("R1", "cfg_xfer", cfg_xfer, 1'b0);
            chk("R1", "chip_ready", chip_ready, 1'b0);
        end
        {en_pin, vin_ok, ref_stable, vcc_ok, vdd_ok} = 5'b01111;

        for (int i = 0; i < 3; i++) begin
            logic [3:0] exp_after;
            case (i)
                0: begin mem[0] = 16'h0000; mem[1] = 16'h0001; mem[2] = 16'hFC90; end
                1: begin mem[0] = 16'h0180; mem[1] = 16'h0000; mem[2] = 16'hFC8D; end
                default: begin mem[0] = 16'h0030; mem[1] = 16'h000A; mem[2] = 16'h8EAB; end
            endcase
            lat = i;
            en_pin = 1'b0;
            repeat (2) @(negedge clk);
            idle_checks("R10");
            chk("R1", "supply_ok low", supply_ok, 1'b0);

            log_clr = 1'b1;
            @(negedge clk);
            log_clr = 1'b0;
            en_pin = 1'b1;
            #1 chk("R1", "supply_ok high", supply_ok, 1'b1);
            count_reset(9, "R2");
            count_load("R3");
            chk("R3", "words read", acnt, 3);
            for (int a = 0; a < 3; a++) chk("R3", "address order", alog[a], a);
            chk("R4", "gpio_oe", gpio_oe, exp_oe());
            chk("R4", "bus_role", bus_role, mem[0][8]);

            // R6/R7: all pin patterns with no host enables.
            for (int g = 0; g < 256; g++) begin
                gpio_in = 8'(g);
                @(negedge clk);
                chk("R7", "ch_en vs pins", ch_en, exp_ch(8'(g), 4'h0));
            end
            gpio_in = 8'h00;

            // R8: every host mask.
            for (int h = 0; h < 16; h++) begin
                host_en_we = 1'b1; host_en_data = 4'(h);
                @(negedge clk);
                host_en_we = 1'b0;
                @(negedge clk);
                chk("R8", "ch_en vs host", ch_en, exp_ch(8'h00, 4'(h)));
            end

            // R9: soft reset in ready restarts; requests during load ignored.
            soft_rst_req = 1'b1;
            @(negedge clk);
            soft_rst_req = 1'b0;
            chk("R9", "sys_rst_n after soft", sys_rst_n, 1'b0);
            chk("R9", "ready after soft", chip_ready, 1'b0);
            chk("R6", "ch_en out of ready", ch_en, 4'h0);
            count_reset(8, "R9");
            soft_rst_req = 1'b1; host_en_we = 1'b1; host_en_data = 4'hF;
            count_load("R9");
            soft_rst_req = 1'b0; host_en_we = 1'b0;
            @(negedge clk);
            chk("R9", "soft ignored in load", chip_ready, 1'b1);
            exp_after = exp_ch(8'h00, 4'h0);
            chk("R8", "host cleared, load write ignored", ch_en, exp_after);

            // R10: supply loss in ready.
            gpio_in = 8'hFF; host_en_we = 1'b1; host_en_data = 4'hF;
            @(negedge clk);
            host_en_we = 1'b0;
            chk("R6", "all enabled", ch_en, 4'hF);
            vdd_ok = 1'b0;
            @(negedge clk);
            chk("R10", "ready after drop", chip_ready, 1'b0);
            chk("R10", "ch_en after drop", ch_en, 4'h0);
            chk("R10", "cfg_xfer after drop", cfg_xfer, 1'b0);
            chk("R11", "gpio_oe after drop", gpio_oe, 8'h00);
            vdd_ok = 1'b1;
            gpio_in = 8'h00;
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule